// File: doc/BRIEF.md
# Bridge Fault Protection Supervisor

This block watches three digital fault indications for a power bridge: a supply-low flag, one overcurrent flag per switch, and an over-temperature flag paired with a cool-down flag from the temperature comparator. It combines them into one request that switches the whole bridge off. It also reports one status bit per fault. The comparators and their thresholds sit outside the block. Only their logic-level results arrive here.

Each fault recovers under its own rule, and none of them needs an external clear. Supply-low is a pure level: the bridge is off while it is flagged. An overcurrent counts only once it has lasted past a deglitch window. It then forces a fixed retry interval, and that interval starts again if the condition is still there afterwards. Over-temperature holds the bridge off until the cool-down flag reports that the die has fallen below the release point. Once every status bit is clear, the bridge follows its command inputs again. Both timing windows are parameters counted in clock cycles. Their defaults assume a 100 MHz clock: 150 cycles of deglitch and 300000 cycles of retry.

Top module: `bridge_fault_supervisor`

## Requirements
- R1: `uv_stat` equals the value `uv_flag` had at the previous rising clock edge, so it sets one cycle after the flag rises and clears one cycle after the flag falls.
- R2: `oc_stat` rises only after at least one bit of `oc_flags` has been high for DEG_CYC+1 consecutive clock edges. A shorter run on any switch leaves `oc_stat` low.
- R3: Once raised, `oc_stat` stays high for exactly RETRY_CYC cycles and then clears without any external action, whatever `oc_flags` does during that time.
- R4: If the overcurrent is still flagged when the retry ends, a new deglitch window of DEG_CYC+1 cycles starts. The disable and retry cycle then repeats for as long as the flag persists: RETRY_CYC cycles high, then DEG_CYC+1 cycles low.
- R5: `ot_stat` sets one cycle after `ot_flag` is seen high. It then stays set while `cool_flag` is low, even after `ot_flag` falls. `ot_flag` high overrides `cool_flag`.
- R6: With `ot_stat` set, a cycle where `cool_flag` is high and `ot_flag` is low clears `ot_stat` at the next edge.
- R7: `bridge_off` is high exactly when at least one of `uv_stat`, `oc_stat` or `ot_stat` is high. After reset all four outputs are low.
- R8: A supply-low event during an overcurrent retry neither restarts nor shortens the retry count. `bridge_off` stays high until both the supply-low status and the retry have ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| uv_flag | input | 1 | Supply undervoltage indication |
| oc_flags | input | NUM_SW | Overcurrent indication, one bit per bridge switch |
| ot_flag | input | 1 | Die above shutdown temperature |
| cool_flag | input | 1 | Die below shutdown temperature minus hysteresis |
| bridge_off | output | 1 | Request to turn every bridge switch off |
| uv_stat | output | 1 | Undervoltage disable active |
| oc_stat | output | 1 | Overcurrent retry interval active |
| ot_stat | output | 1 | Thermal shutdown active |

## Verification
The hardest case to reach is an overlap between the two timed and level faults. A supply-low event has to begin inside a running overcurrent retry, and it has to end either before or after that retry expires. The bench gets there by raising one switch's overcurrent flag for exactly the deglitch length, then raising `uv_flag` a fixed number of cycles after `oc_stat` rises. It counts the high cycles of each status bit and of `bridge_off` across the whole episode. It also sweeps the pulse length across the deglitch boundary on every switch, and holds an overcurrent flag long enough to observe three complete retry periods.

// File: rtl/bfs_pkg.sv
package bfs_pkg;
    typedef enum logic [0:0] {
        OC_WATCH = 1'b0,
        OC_RETRY = 1'b1
    } oc_state_e;
endpackage

// File: rtl/bfs_uv_level.sv
module bfs_uv_level (
    input  logic clk,
    input  logic rst_n,
    input  logic uv_in,
    output logic uv_active
);
    logic uv_d, uv_q;

    always_comb begin
        uv_d = uv_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) uv_q <= 1'b0;
        else        uv_q <= uv_d;
    end

    assign uv_active = uv_q;

    p_uv_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
        uv_in |=> uv_active);
    p_uv_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !uv_in |=> !uv_active);
endmodule

// File: rtl/bfs_oc_retry.sv
module bfs_oc_retry
    import bfs_pkg::*;
#(
    parameter int NUM_SW    = 4,
    parameter int DEG_CYC   = 150,
    parameter int RETRY_CYC = 300000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_SW-1:0] oc_in,
    output logic              retry_active
);
    localparam int GW = $clog2(DEG_CYC + 1);
    localparam int RW = (RETRY_CYC > 1) ? $clog2(RETRY_CYC) : 1;
    localparam logic [GW-1:0] G_LAST = GW'(DEG_CYC);
    localparam logic [RW-1:0] R_LAST = RW'(RETRY_CYC - 1);

    typedef struct packed {
        oc_state_e       st;
        logic [GW-1:0]   gcnt;
        logic [RW-1:0]   rcnt;
    } oc_regs_t;

    oc_regs_t d, q;
    logic     oc_any;

    assign oc_any = |oc_in;

    always_comb begin
        d = q;
        unique case (q.st)
            OC_WATCH: begin
                if (oc_any) begin
                    if (q.gcnt == G_LAST) begin
                        d.st   = OC_RETRY;
                        d.gcnt = '0;
                        d.rcnt = '0;
                    end else begin
                        d.gcnt = q.gcnt + GW'(1);
                    end
                end else begin
                    d.gcnt = '0;
                end
            end
            OC_RETRY: begin
                if (q.rcnt == R_LAST) begin
                    d.st   = OC_WATCH;
                    d.rcnt = '0;
                    d.gcnt = '0;
                end else begin
                    d.rcnt = q.rcnt + RW'(1);
                end
            end
            default: d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign retry_active = (q.st == OC_RETRY);

    p_entry_needs_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(retry_active) |-> $past(oc_any));
    p_retry_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (retry_active && q.rcnt != R_LAST) |=> retry_active);
    p_retry_ends_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (retry_active && q.rcnt == R_LAST) |=> !retry_active);
    p_rearm_from_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(retry_active) |-> (q.gcnt == '0));
endmodule

// File: rtl/bfs_thermal_hold.sv
module bfs_thermal_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic hot_in,
    input  logic cool_in,
    output logic shut_active
);
    logic shut_d, shut_q;

    always_comb begin
        shut_d = shut_q;
        if (hot_in)       shut_d = 1'b1;
        else if (cool_in) shut_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shut_q <= 1'b0;
        else        shut_q <= shut_d;
    end

    assign shut_active = shut_q;

    p_hot_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
        hot_in |=> shut_active);
    p_hold_until_cool_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (shut_active && !cool_in) |=> shut_active);
    p_cool_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!hot_in && cool_in) |=> !shut_active);
endmodule

// File: rtl/bridge_fault_supervisor.sv
module bridge_fault_supervisor #(
    parameter int NUM_SW    = 4,
    parameter int DEG_CYC   = 150,
    parameter int RETRY_CYC = 300000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              uv_flag,
    input  logic [NUM_SW-1:0] oc_flags,
    input  logic              ot_flag,
    input  logic              cool_flag,
    output logic              bridge_off,
    output logic              uv_stat,
    output logic              oc_stat,
    output logic              ot_stat
);
    bfs_uv_level u_uv (
        .clk       (clk),
        .rst_n     (rst_n),
        .uv_in     (uv_flag),
        .uv_active (uv_stat)
    );

    bfs_oc_retry #(
        .NUM_SW    (NUM_SW),
        .DEG_CYC   (DEG_CYC),
        .RETRY_CYC (RETRY_CYC)
    ) u_oc (
        .clk          (clk),
        .rst_n        (rst_n),
        .oc_in        (oc_flags),
        .retry_active (oc_stat)
    );

    bfs_thermal_hold u_ot (
        .clk         (clk),
        .rst_n       (rst_n),
        .hot_in      (ot_flag),
        .cool_in     (cool_flag),
        .shut_active (ot_stat)
    );

    assign bridge_off = uv_stat | oc_stat | ot_stat;

    p_off_after_uv_r7: assert property (@(posedge clk) disable iff (!rst_n)
        uv_flag |=> bridge_off);
    p_off_after_hot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ot_flag |=> bridge_off);
    p_uv_keeps_retry_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (oc_stat && uv_flag && $past(oc_stat) && !$fell(oc_stat)) |=> (bridge_off));
endmodule

// File: tb/bridge_fault_supervisor_bench.sv
module bridge_fault_supervisor_bench;
    localparam int NSW = 2;
    localparam int DEG = 3;
    localparam int RET = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           uv_flag = 1'b0;
    logic [NSW-1:0] oc_flags = '0;
    logic           ot_flag = 1'b0;
    logic           cool_flag = 1'b0;
    logic           bridge_off, uv_stat, oc_stat, ot_stat;

    int errors = 0;
    int checks = 0;
    int mism   = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    bridge_fault_supervisor #(.NUM_SW(NSW), .DEG_CYC(DEG), .RETRY_CYC(RET)) u_bridge_fault_supervisor (
        .clk(clk), .rst_n(rst_n), .uv_flag(uv_flag), .oc_flags(oc_flags),
        .ot_flag(ot_flag), .cool_flag(cool_flag), .bridge_off(bridge_off),
        .uv_stat(uv_stat), .oc_stat(oc_stat), .ot_stat(ot_stat)
    );

    // R7: combine rule checked on every sample
    always @(negedge clk) begin
        if (rst_n && (bridge_off !== (uv_stat | oc_stat | ot_stat))) mism++;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic oc_pulse(input int sw, input int n);
        int hi_oc = 0;
        int hi_off = 0;
        int exp;
        @(negedge clk);
        oc_flags[sw] = 1'b1;
        for (int k = 1; k <= n + RET + DEG + 4; k++) begin
            @(negedge clk);
            if (oc_stat) hi_oc++;
            if (bridge_off) hi_off++;
            if (k == n) oc_flags[sw] = 1'b0;
        end
        exp = (n > DEG) ? RET : 0;
        chk(hi_oc == exp, $sformatf("R2/R3 sw%0d len%0d oc_stat cycles", sw, n), hi_oc, exp);
        chk(hi_off == exp, $sformatf("R7 sw%0d len%0d bridge_off cycles", sw, n), hi_off, exp);
    endtask

    task automatic uv_in_retry(input int uv_off_k, input int exp_off);
        int hi_oc = 0;
        int hi_uv = 0;
        int hi_off = 0;
        @(negedge clk);
        oc_flags[1] = 1'b1;
        for (int k = 1; k <= DEG + RET + 12; k++) begin
            @(negedge clk);
            if (oc_stat) hi_oc++;
            if (uv_stat) hi_uv++;
            if (bridge_off) hi_off++;
            if (k == DEG + 1) oc_flags[1] = 1'b0;
            if (k == DEG + 3) uv_flag = 1'b1;
            if (k == uv_off_k) uv_flag = 1'b0;
        end
        chk(hi_oc == RET, "R8 retry length with supply-low overlap", hi_oc, RET);
        chk(hi_uv == uv_off_k - DEG - 3, "R1 uv_stat cycles", hi_uv, uv_off_k - DEG - 3);
        chk(hi_off == exp_off, "R8 bridge_off cycles over overlap", hi_off, exp_off);
    endtask

    initial begin
        #(4 * 20000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int hi, rises;
        bit prev;
        repeat (3) @(negedge clk);
        chk({bridge_off, uv_stat, oc_stat, ot_stat} == 4'b0, "R7 reset state",
            {bridge_off, uv_stat, oc_stat, ot_stat}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(bridge_off == 1'b0, "R7 idle after reset", bridge_off, 0);

        // R1 level supply-low
        uv_flag = 1'b1;
        @(negedge clk);
        chk(uv_stat && bridge_off, "R1 uv sets in one cycle", uv_stat, 1);
        repeat (3) @(negedge clk);
        chk(uv_stat == 1'b1, "R1 uv holds", uv_stat, 1);
        uv_flag = 1'b0;
        @(negedge clk);
        chk(!uv_stat && !bridge_off, "R1 uv clears in one cycle", uv_stat, 0);

        // R2/R3 pulse length sweep on each switch
        for (int sw = 0; sw < NSW; sw++)
            for (int n = 1; n <= 8; n++)
                oc_pulse(sw, n);

        // R4 persistent overcurrent repeats
        @(negedge clk);
        oc_flags[0] = 1'b1;
        for (int k = 0; k < 20 && !oc_stat; k++) @(negedge clk);
        hi = 0; rises = 0; prev = 1'b0;
        for (int k = 0; k < 3 * (RET + DEG + 1); k++) begin
            if (oc_stat) hi++;
            if (oc_stat && !prev) rises++;
            prev = oc_stat;
            @(negedge clk);
        end
        chk(hi == 3 * RET, "R4 repeated retry high cycles", hi, 3 * RET);
        chk(rises == 3, "R4 repeated retry count", rises, 3);
        oc_flags[0] = 1'b0;
        repeat (RET + 4) @(negedge clk);
        chk(!oc_stat && !bridge_off, "R3 recovery after flag drops", oc_stat, 0);

        // R8 supply-low inside retry, ending before and after it
        uv_in_retry(DEG + 6, RET);
        uv_in_retry(DEG + RET + 5, RET + 5);

        // R5/R6 thermal hysteresis
        ot_flag = 1'b1;
        @(negedge clk);
        chk(ot_stat && bridge_off, "R5 thermal sets", ot_stat, 1);
        ot_flag = 1'b0;
        repeat (5) @(negedge clk);
        chk(ot_stat == 1'b1, "R5 thermal holds without cool flag", ot_stat, 1);
        ot_flag = 1'b1; cool_flag = 1'b1;
        @(negedge clk);
        chk(ot_stat == 1'b1, "R5 hot overrides cool", ot_stat, 1);
        ot_flag = 1'b0;
        @(negedge clk);
        chk(!ot_stat && !bridge_off, "R6 cool flag releases", ot_stat, 0);
        cool_flag = 1'b0;
        @(negedge clk);
        chk(ot_stat == 1'b0, "R6 stays released", ot_stat, 0);

        chk(mism == 0, "R7 bridge_off equals OR of status bits", mism, 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule